// File: doc/BRIEF.md
# Windowed Keyed Watchdog Timer

This block is a watchdog that counts up toward a programmable 32-bit limit and asks for a system reset unless software services it correctly. Software talks to it through a simple single-cycle write port. Three addresses hold the configuration: the control word, the time-out limit and the window start. A fourth address is the service port, and 16-bit keys are written there in pairs. One pair of keys restarts the counter. The other pair opens the configuration for a short, fixed span of bus cycles.

The counter advances only on a one-cycle tick input, which stands for the chosen watchdog clock. Each key pair must complete within a fixed number of bus cycles. A broken pair, a restart that comes too early in windowed mode, or a counter that reaches its limit all count as a fault. A fault either drives the reset request at once or first raises an interrupt and then asks for reset a fixed number of ticks later. A sticky flag records that the watchdog caused the reset. Only the power-on reset input clears that flag.

The clock-source select and the test bit are held in the control word and shown on its readback, but nothing inside the block uses them.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs hold their reset values: `cnt_o`=0, `ctrl_o`=9'h001 (only the enable bit is set), `tmo_o`=RST_TIMEOUT, `win_o`=0, `wd_irq`=0, `wd_rst`=0 and `cfg_open_o`=1. `wd_flag` reads 0 after a power-on reset.
- R2: The bits of `ctrl_o` are: 0 enable, 1 windowed mode, 2 interrupt before reset, 3 run in wait, 4 run in stop, 5 run in debug, 7:6 clock select, 8 test. While the counter is allowed to run, it goes up by exactly one on each cycle where `tick` is high. It does not move on other cycles, and it never counts past `tmo_o`.
- R3: A write of 16'hA602 to the service address (3, low 16 bits), followed by a write of 16'hB480 at most 20 cycles later, clears `cnt_o` to 0 and causes no fault.
- R4: A key sequence fault requests a reset on the following cycle. A sequence fault is any of: a service write that is not a valid first key, a wrong second key, or no second key by the 20th cycle after the first key.
- R5: A write of 16'hC520 followed by a write of 16'hD928 at most 20 cycles later opens the configuration for the next 256 cycles. Writes to address 0 (control), 1 (time-out) and 2 (window) take effect only while the configuration is open. At any other time these writes leave all readbacks unchanged.
- R6: After `rst_n` is released, the configuration is open for the first 256 cycles, and then it locks.
- R7: While the counter is allowed to run and `cnt_o` has reached `tmo_o`, a fault is raised.
- R8: In windowed mode, a valid restart while `cnt_o` is below `win_o` is a fault. A restart with `cnt_o` at or above `win_o` is accepted.
- R9: When `in_wait`, `in_stop` or `in_debug` is high and its matching run bit is clear, the counter holds its value.
- R10: With the interrupt-before-reset bit clear, a fault sets `wd_rst` on the next cycle. With the bit set, `wd_irq` rises on the next cycle, and `wd_rst` rises on the 128th tick after that, at which point `wd_irq` falls. The two outputs are never high together.
- R11: `wd_flag` goes high on the cycle after `wd_rst` goes high. It stays high through `rst_n` resets and is cleared only by `por_n`.
- R12: Once high, `wd_rst` stays high until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, clears the flag |
| tick | input | 1 | One-cycle watchdog clock enable |
| in_wait | input | 1 | System is in wait mode |
| in_stop | input | 1 | System is in stop mode |
| in_debug | input | 1 | System is halted for debug |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | 0 control, 1 time-out, 2 window, 3 service keys |
| bus_wdata | input | 32 | Write data |
| wd_irq | output | 1 | Pending-reset interrupt |
| wd_rst | output | 1 | System reset request |
| wd_flag | output | 1 | Watchdog-caused reset flag |
| cnt_o | output | 32 | Counter value |
| ctrl_o | output | 9 | Control word readback |
| tmo_o | output | 32 | Time-out limit readback |
| win_o | output | 32 | Window start readback |
| cfg_open_o | output | 1 | Configuration currently writable |

## Verification
Some properties are checked on every cycle. The counter may only step by one or drop to zero. A locked configuration may not change. The interrupt and reset outputs are never high together. The reset request and the flag are sticky. A stalled mode must freeze the count, and the interrupt may only appear when its control bit was set. Other behaviour needs the bench's scenarios, because it depends on exact cycle counts. That covers the last cycle on which a second key or a configuration write is still accepted, the time-out cycle, the window limit, and the 128-tick delay from interrupt to reset. The same holds for how the count follows random ticks and mode inputs.

// File: rtl/wdog_keyed_pkg.sv
// Shared definitions for the keyed watchdog: control word layout,
// register addresses, service keys and response states.
package wdog_keyed_pkg;

    // Control word; the first member is the most significant bit.
    typedef struct packed {
        logic       test_en;   // bit 8, stored only
        logic [1:0] clk_sel;   // bits 7:6, stored only
        logic       dbg_run;   // bit 5
        logic       stop_run;  // bit 4
        logic       wait_run;  // bit 3
        logic       irq_first; // bit 2
        logic       win_en;    // bit 1
        logic       en;        // bit 0
    } wd_ctrl_t;

    localparam int CTRL_W = $bits(wd_ctrl_t);

    localparam wd_ctrl_t CTRL_RST = '{test_en: 1'b0, clk_sel: 2'd0,
                                      dbg_run: 1'b0, stop_run: 1'b0,
                                      wait_run: 1'b0, irq_first: 1'b0,
                                      win_en: 1'b0, en: 1'b1};

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_TMO  = 2'd1,
        A_WIN  = 2'd2,
        A_SVC  = 2'd3
    } wd_addr_e;

    localparam logic [15:0] KEY_REF_A = 16'hA602;
    localparam logic [15:0] KEY_REF_B = 16'hB480;
    localparam logic [15:0] KEY_UNL_A = 16'hC520;
    localparam logic [15:0] KEY_UNL_B = 16'hD928;

    typedef enum logic [1:0] {
        RS_RUN = 2'd0,
        RS_IRQ = 2'd1,
        RS_RST = 2'd2
    } wd_resp_e;

endpackage

// File: rtl/wdog_keyed_seq.sv
// Key pair detector for the service port.
// What it does: recognises the restart pair and the unlock pair, and
// flags any broken sequence as a fault.
// Assumptions: svc_wr is high for one cycle per write. The gap is counted
// in bus cycles, and a second key that arrives KEY_GAP cycles after the
// first is still accepted.
module wdog_keyed_seq
    import wdog_keyed_pkg::*;
#(
    parameter int KEY_GAP = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_key,
    output logic        refresh_ok,
    output logic        unlock_ok,
    output logic        seq_fault
);

    localparam int              GAP_W    = $clog2(KEY_GAP + 2);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(KEY_GAP);

    typedef enum logic [1:0] {SQ_IDLE, SQ_REF, SQ_UNL} sq_e;

    sq_e              st_q, st_d;
    logic [GAP_W-1:0] gap_q;

    // Decide the next sequence state and the one-cycle result pulses.
    always_comb begin
        st_d       = st_q;
        refresh_ok = 1'b0;
        unlock_ok  = 1'b0;
        seq_fault  = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                if (svc_wr) begin
                    if (svc_key == KEY_REF_A)      st_d = SQ_REF;
                    else if (svc_key == KEY_UNL_A) st_d = SQ_UNL;
                    else                           seq_fault = 1'b1;
                end
            end
            SQ_REF: begin
                if (svc_wr) begin
                    st_d = SQ_IDLE;
                    if (svc_key == KEY_REF_B) refresh_ok = 1'b1;
                    else                      seq_fault  = 1'b1;
                end else if (gap_q == GAP_LAST) begin
                    st_d      = SQ_IDLE;
                    seq_fault = 1'b1;
                end
            end
            SQ_UNL: begin
                if (svc_wr) begin
                    st_d = SQ_IDLE;
                    if (svc_key == KEY_UNL_B) unlock_ok = 1'b1;
                    else                      seq_fault = 1'b1;
                end else if (gap_q == GAP_LAST) begin
                    st_d      = SQ_IDLE;
                    seq_fault = 1'b1;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // Hold the state and count the bus cycles since the first key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            gap_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE) gap_q <= GAP_W'(1);
            else                 gap_q <= gap_q + GAP_W'(1);
        end
    end

endmodule

// File: rtl/wdog_keyed_cfg.sv
// Configuration registers and the span during which they can be written.
// What it does: holds the control word, the time-out limit and the window
// start, and accepts writes to them only while the open span runs.
// Assumptions: the span starts with CFG_OPEN cycles after reset and is
// reloaded by every valid unlock.
module wdog_keyed_cfg
    import wdog_keyed_pkg::*;
#(
    parameter int               CNT_W       = 32,
    parameter int               CFG_OPEN    = 256,
    parameter logic [CNT_W-1:0] RST_TIMEOUT = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             unlock_ok,
    output wd_ctrl_t         ctrl,
    output logic [CNT_W-1:0] tmo,
    output logic [CNT_W-1:0] win,
    output logic             cfg_open
);

    localparam int              OPEN_W    = $clog2(CFG_OPEN + 1);
    localparam logic [OPEN_W-1:0] OPEN_LOAD = OPEN_W'(CFG_OPEN);

    logic [OPEN_W-1:0] open_q;

    assign cfg_open = (open_q != '0);

    // Count down the remaining writable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         open_q <= OPEN_LOAD;
        else if (unlock_ok) open_q <= OPEN_LOAD;
        else if (cfg_open)  open_q <= open_q - OPEN_W'(1);
    end

    // Take configuration writes while the span is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
            tmo  <= RST_TIMEOUT;
            win  <= '0;
        end else if (bus_wr && cfg_open) begin
            case (bus_addr)
                A_CTRL:  ctrl <= wd_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_TMO:   tmo  <= bus_wdata;
                A_WIN:   win  <= bus_wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wdog_keyed_cnt.sv
// Watchdog counter with time-out and window checks.
// What it does: counts ticks while the counter may run, clears on a valid
// restart, and reports a time-out or a restart that came too early.
// Assumptions: tick is high for one cycle per watchdog clock period, and
// the counter stops at the limit.
module wdog_keyed_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             win_en,
    input  logic [2:0]       mode_in,
    input  logic [2:0]       mode_run,
    input  logic [CNT_W-1:0] tmo,
    input  logic [CNT_W-1:0] win,
    input  logic             refresh_ok,
    output logic [CNT_W-1:0] cnt,
    output logic             tmo_fault,
    output logic             win_fault
);

    logic [2:0] blocked;
    logic       run;

    // A mode stalls the counter when it is active and its run bit is clear.
    for (genvar m = 0; m < 3; m++) begin : g_gate
        assign blocked[m] = mode_in[m] & ~mode_run[m];
    end

    assign run       = en & ~(|blocked);
    assign tmo_fault = run & (cnt >= tmo);
    assign win_fault = refresh_ok & win_en & (cnt < win);

    // Advance on ticks below the limit and clear on a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (refresh_ok)                cnt <= '0;
        else if (tick && run && cnt < tmo)  cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/wdog_keyed_resp.sv
// Fault response sequencer and the watchdog-reset flag.
// What it does: turns the first fault into an immediate reset request,
// or into an interrupt that is followed by a reset after IRQ_DELAY ticks.
// Assumptions: the request holds until rst_n; the flag uses por_n only.
module wdog_keyed_resp
    import wdog_keyed_pkg::*;
#(
    parameter int IRQ_DELAY = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic tick,
    input  logic irq_first,
    input  logic fault,
    output logic wd_irq,
    output logic wd_rst,
    output logic wd_flag
);

    localparam int              DLY_W    = $clog2(IRQ_DELAY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(IRQ_DELAY - 1);

    wd_resp_e         st_q;
    logic [DLY_W-1:0] dly_q;

    assign wd_irq = (st_q == RS_IRQ);
    assign wd_rst = (st_q == RS_RST);

    // Step from running to interrupt or reset and count the delay ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RS_RUN;
            dly_q <= '0;
        end else begin
            case (st_q)
                RS_RUN: if (fault) begin
                    st_q  <= irq_first ? RS_IRQ : RS_RST;
                    dly_q <= '0;
                end
                RS_IRQ: if (tick) begin
                    if (dly_q == DLY_LAST) st_q  <= RS_RST;
                    else                   dly_q <= dly_q + DLY_W'(1);
                end
                default: st_q <= RS_RST;
            endcase
        end
    end

    // Record a watchdog reset until power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n)      wd_flag <= 1'b0;
        else if (wd_rst) wd_flag <= 1'b1;
    end

endmodule

// File: rtl/wdog_keyed.sv
// Top of the keyed watchdog.
// What it does: connects the key detector, the configuration block, the
// counter and the fault response, and decodes the single write port.
// Assumptions: the bus write port and the data width match the counter
// width; rst_n is driven low by the system after wd_rst is asserted.
module wdog_keyed
    import wdog_keyed_pkg::*;
#(
    parameter int               CNT_W       = 32,
    parameter int               KEY_GAP     = 20,
    parameter int               CFG_OPEN    = 256,
    parameter int               IRQ_DELAY   = 128,
    parameter logic [CNT_W-1:0] RST_TIMEOUT = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick,
    input  logic              in_wait,
    input  logic              in_stop,
    input  logic              in_debug,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic              wd_irq,
    output logic              wd_rst,
    output logic              wd_flag,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  tmo_o,
    output logic [CNT_W-1:0]  win_o,
    output logic              cfg_open_o
);

    wd_ctrl_t         ctrl;
    logic [CNT_W-1:0] tmo, win;
    logic             svc_wr, refresh_ok, unlock_ok;
    logic             seq_fault, tmo_fault, win_fault;

    assign svc_wr = bus_wr && (bus_addr == A_SVC);

    wdog_keyed_seq #(.KEY_GAP(KEY_GAP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_wr     (svc_wr),
        .svc_key    (bus_wdata[15:0]),
        .refresh_ok (refresh_ok),
        .unlock_ok  (unlock_ok),
        .seq_fault  (seq_fault)
    );

    wdog_keyed_cfg #(
        .CNT_W       (CNT_W),
        .CFG_OPEN    (CFG_OPEN),
        .RST_TIMEOUT (RST_TIMEOUT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .unlock_ok (unlock_ok),
        .ctrl      (ctrl),
        .tmo       (tmo),
        .win       (win),
        .cfg_open  (cfg_open_o)
    );

    wdog_keyed_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .en         (ctrl.en),
        .win_en     (ctrl.win_en),
        .mode_in    ({in_debug, in_stop, in_wait}),
        .mode_run   ({ctrl.dbg_run, ctrl.stop_run, ctrl.wait_run}),
        .tmo        (tmo),
        .win        (win),
        .refresh_ok (refresh_ok),
        .cnt        (cnt_o),
        .tmo_fault  (tmo_fault),
        .win_fault  (win_fault)
    );

    wdog_keyed_resp #(.IRQ_DELAY(IRQ_DELAY)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .tick      (tick),
        .irq_first (ctrl.irq_first),
        .fault     (seq_fault | tmo_fault | win_fault),
        .wd_irq    (wd_irq),
        .wd_rst    (wd_rst),
        .wd_flag   (wd_flag)
    );

    assign ctrl_o = ctrl;
    assign tmo_o  = tmo;
    assign win_o  = win;

endmodule

// File: rtl/wdog_keyed_chk.sv
// Checker for the keyed watchdog, bound to every instance of the top.
// What it does: checks on every cycle the rules that hold at the ports.
// Assumptions: rst_n is held low for at least two cycles at start-up.
module wdog_keyed_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             in_wait,
    input logic             wd_irq,
    input logic             wd_rst,
    input logic             wd_flag,
    input logic [CNT_W-1:0] cnt_o,
    input logic [8:0]       ctrl_o,
    input logic [CNT_W-1:0] tmo_o,
    input logic [CNT_W-1:0] win_o,
    input logic             cfg_open_o
);

    // R2: the count moves only by one step up, or to zero on a restart.
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));

    // R5: a locked configuration does not change.
    p_locked_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open_o |=> ($stable(ctrl_o) && $stable(tmo_o) && $stable(win_o)));

    // R9: wait mode with its run bit clear freezes the count, except for a restart.
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !ctrl_o[3]) |=> (cnt_o == $past(cnt_o) || cnt_o == '0));

    // R10: the interrupt and the reset request are never high together.
    p_irq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_irq && wd_rst));

    // R10: the interrupt only appears when its control bit was set.
    p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq) |-> $past(ctrl_o[2]));

    // R12: the reset request holds until rst_n.
    p_rst_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> wd_rst);

    // R11: the flag follows the reset request.
    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wd_rst |=> wd_flag);

    // R11: the flag clears only through por_n.
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
        wd_flag |=> wd_flag);

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .in_wait    (in_wait),
    .wd_irq     (wd_irq),
    .wd_rst     (wd_rst),
    .wd_flag    (wd_flag),
    .cnt_o      (cnt_o),
    .ctrl_o     (ctrl_o),
    .tmo_o      (tmo_o),
    .win_o      (win_o),
    .cfg_open_o (cfg_open_o)
);

// File: tb/wdog_keyed_tb.sv
// Bench for the keyed watchdog. It combines directed boundary cases with
// randomly driven count phases that are checked against a bench model.
module wdog_keyed_tb;

    localparam logic [31:0] RST_TMO = 32'h0000_FFFF;
    localparam logic [1:0]  AD_CTRL = 2'd0, AD_TMO = 2'd1, AD_WIN = 2'd2, AD_SVC = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n, por_n, tick, in_wait, in_stop, in_debug, bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        wd_irq, wd_rst, wd_flag, cfg_open_o;
    logic [31:0] cnt_o, tmo_o, win_o;
    logic [8:0]  ctrl_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    wdog_keyed #(.RST_TIMEOUT(RST_TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
        .in_wait(in_wait), .in_stop(in_stop), .in_debug(in_debug),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wd_irq(wd_irq), .wd_rst(wd_rst), .wd_flag(wd_flag),
        .cnt_o(cnt_o), .ctrl_o(ctrl_o), .tmo_o(tmo_o), .win_o(win_o),
        .cfg_open_o(cfg_open_o)
    );

    function automatic bit may_run(logic [8:0] c, logic w, logic s, logic d);
        return c[0] && !(w && !c[3]) && !(s && !c[4]) && !(d && !c[5]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rst_sys();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [8:0] c, input logic [31:0] t, input logic [31:0] w);
        rst_sys();
        wr(AD_CTRL, {23'd0, c});
        wr(AD_TMO, t);
        wr(AD_WIN, w);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        logic [8:0]  c;
        void'($urandom(32'd4242));
        rst_n = 0; por_n = 0; tick = 0; in_wait = 0; in_stop = 0; in_debug = 0;
        bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        step(3);
        rst_n = 1; por_n = 1;

        // R1 reset state
        check(cnt_o == 0, "R1 cnt", cnt_o, 0);
        check(ctrl_o == 9'h001, "R1 ctrl", {23'd0, ctrl_o}, 1);
        check(tmo_o == RST_TMO, "R1 tmo", tmo_o, RST_TMO);
        check(win_o == 0 && cfg_open_o, "R1 win/open", win_o, 0);
        check(!wd_irq && !wd_rst && !wd_flag, "R1 outputs",
              {29'd0, wd_irq, wd_rst, wd_flag}, 0);

        // R6 last accepted cycle of the open span after reset, then locked
        step(255);
        wr(AD_TMO, 32'd77);
        check(tmo_o == 77, "R6 last open write", tmo_o, 77);
        wr(AD_TMO, 32'd88);
        check(tmo_o == 77 && !cfg_open_o, "R6 locked write ignored", tmo_o, 77);
        wr(AD_CTRL, 32'h1FE);
        check(ctrl_o == 9'h001, "R5 locked ctrl ignored", {23'd0, ctrl_o}, 1);

        // R5 unlock and the 256-cycle span
        wr(AD_SVC, 32'hC520);
        wr(AD_SVC, 32'hD928);
        check(cfg_open_o == 1'b1, "R5 open after unlock", {31'd0, cfg_open_o}, 1);
        step(255);
        wr(AD_WIN, 32'd5);
        check(win_o == 5, "R5 last open write", win_o, 5);
        wr(AD_WIN, 32'd6);
        check(win_o == 5, "R5 write after span ignored", win_o, 5);

        // R2 count on ticks, R3 restart with the largest gap
        tick = 1; step(5); tick = 0;
        check(cnt_o == 5, "R2 count ticks", cnt_o, 5);
        wr(AD_SVC, 32'hA602);
        step(19);
        wr(AD_SVC, 32'hB480);
        check(cnt_o == 0 && !wd_rst, "R3 restart at gap 20", cnt_o, 0);

        // R4 second key too late
        wr(AD_SVC, 32'hA602);
        step(19);
        check(!wd_rst, "R4 no fault before gap ends", {31'd0, wd_rst}, 0);
        step(1);
        check(wd_rst, "R4 fault at gap end", {31'd0, wd_rst}, 1);
        step(1);
        check(wd_flag, "R11 flag set", {31'd0, wd_flag}, 1);
        step(4);
        check(wd_rst, "R12 reset request held", {31'd0, wd_rst}, 1);
        rst_sys();
        check(wd_flag && !wd_rst, "R11 flag kept over rst_n", {31'd0, wd_flag}, 1);

        // R4 wrong second key, and an invalid first key
        wr(AD_SVC, 32'hA602);
        wr(AD_SVC, 32'hC520);
        check(wd_rst, "R4 wrong second key", {31'd0, wd_rst}, 1);
        rst_sys();
        wr(AD_SVC, 32'h1234);
        check(wd_rst, "R4 invalid first key", {31'd0, wd_rst}, 1);
        rst_n = 0; por_n = 0; step(2); rst_n = 1; por_n = 1;
        check(!wd_flag, "R11 por clears flag", {31'd0, wd_flag}, 0);

        // R7 time-out
        setup(9'h001, 32'd10, 32'd0);
        tick = 1; step(10);
        check(cnt_o == 10 && !wd_rst, "R7 at limit, no reset yet", cnt_o, 10);
        step(1);
        check(wd_rst, "R7 time-out reset", {31'd0, wd_rst}, 1);
        check(cnt_o == 10, "R2 count stops at limit", cnt_o, 10);
        tick = 0;

        // R10 interrupt first, reset after 128 ticks
        setup(9'h005, 32'd10, 32'd0);
        tick = 1; step(11);
        check(wd_irq && !wd_rst, "R10 irq raised", {30'd0, wd_irq, wd_rst}, 2);
        step(127);
        check(wd_irq && !wd_rst, "R10 irq before delay end", {30'd0, wd_irq, wd_rst}, 2);
        step(1);
        check(!wd_irq && wd_rst, "R10 reset after delay", {30'd0, wd_irq, wd_rst}, 1);
        tick = 0;

        // R8 window: early restart faults, restart at the window is fine
        setup(9'h003, 32'd1000, 32'd30);
        tick = 1; step(29); tick = 0;
        wr(AD_SVC, 32'hA602); wr(AD_SVC, 32'hB480);
        check(wd_rst, "R8 early restart faults", {31'd0, wd_rst}, 1);
        setup(9'h003, 32'd1000, 32'd30);
        tick = 1; step(30); tick = 0;
        wr(AD_SVC, 32'hA602); wr(AD_SVC, 32'hB480);
        check(!wd_rst && cnt_o == 0, "R8 restart at window ok", cnt_o, 0);

        // R2 R9 R3 random ticks and modes against the bench model
        for (int r = 0; r < 4; r++) begin
            c = {$urandom_range(1, 0) == 1, 2'($urandom), 3'($urandom), 2'b00,
                 ($urandom % 4) != 0};
            setup(c, 32'd100000, 32'd0);
            exp = 0;
            for (int i = 0; i < 150; i++) begin
                check(cnt_o == exp, "R9 R2 random count", cnt_o, exp);
                if (i == 75) begin
                    tick = 0; in_wait = 0; in_stop = 0; in_debug = 0;
                    wr(AD_SVC, 32'hA602);
                    step($urandom % 20);
                    wr(AD_SVC, 32'hB480);
                    exp = 0;
                    check(cnt_o == 0 && !wd_rst, "R3 random gap restart", cnt_o, 0);
                end
                tick     = ($urandom % 3) != 0;
                in_wait  = ($urandom % 4) == 0;
                in_stop  = ($urandom % 4) == 0;
                in_debug = ($urandom % 4) == 0;
                if (tick && may_run(ctrl_o, in_wait, in_stop, in_debug)) exp = exp + 1;
                step(1);
            end
            tick = 0; in_wait = 0; in_stop = 0; in_debug = 0;
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule